// File: doc/BRIEF.md
# YC Output Formatter with Ranging

This block sits at the tail of a colour-space decimation path. Each clock it is offered one filtered luminance word and two filtered chrominance words (red-difference and blue-difference), all as signed fixed-point values with 15 integer and 3 fractional bits. It turns them into 8-bit bytes and presents them on a 16-bit 4:2:2 bus. The bus carries the luma byte in the upper half and a chroma byte in the lower half. Each output word is held for two clocks, and the chroma byte alternates between the red-difference and the blue-difference channel.

The rounding and clipping depend on three static configuration inputs. A normalisation flag picks which integer window of the chroma word is kept, and which bit is used to round it. A bypass flag chooses between two output formats: two's-complement chroma passed through unchanged, or an offset-binary form with 128 added and range limiting applied. A range-select flag picks one of two broadcast range sets for that limiting. A delayed line-reference input, active low, blanks the bus. It also restarts the sequence, so that the first word of each line carries red-difference chroma. A strobe output marks the first clock of every word, so the next stage can use it as a clock enable.

Top module: `yc_out_formatter`

## Requirements
- R1: Luma takes the 10-bit signed integer window at input bits [12:3] and adds input bit 2 to it. The result is then clipped: negative values become 0 and values above 255 become 255.
- R2: With `cfg_norm` = 1, chroma takes the 9-bit signed integer window at bits [11:3] and adds bit 2 to it. The result is clipped to the signed range -128..127.
- R3: With `cfg_norm` = 0, chroma takes the 9 bits at [12:4] (the upper part of the low 10 integer bits) and adds integer bit 0 (input bit 3) to them. The result is clipped to -128..127.
- R4: With `cfg_bypass` = 1, the luma byte is output as clipped, and the chroma byte is output as two's complement with no offset and no further limiting.
- R5: With `cfg_bypass` = 0, 128 is added to the clipped chroma value, which gives an unsigned offset-binary byte, before range limiting.
- R6: With `cfg_bypass` = 0 and `cfg_sel` = 1, the luma byte and the chroma byte are both limited to 1..254.
- R7: With `cfg_bypass` = 0 and `cfg_sel` = 0, the luma byte is limited to 16..235 and the chroma byte to 16..240.
- R8: While `line_act_n` is high, `word_strobe` alternates every clock. A new word is loaded at the edge that raises `word_strobe`, from the inputs present at that edge. The word is then held unchanged through the following clock, whatever the inputs do.
- R9: The chroma source alternates word by word. The first word loaded after `line_act_n` goes high takes `cr_in`, and the next takes `cb_in`.
- R10: At each edge where `line_act_n` is sampled low, `yc_out` becomes 0 and `word_strobe` becomes 0.
- R11: While `rst_n` is low, `yc_out` and `word_strobe` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_act_n | input | 1 | Delayed line reference; low blanks the bus and restarts the sequence |
| cfg_norm | input | 1 | 1: normalised chroma window; 0: full-range window |
| cfg_bypass | input | 1 | 1: pass two's-complement chroma; 0: offset and range limiting |
| cfg_sel | input | 1 | 1: limits 1..254; 0: luma 16..235, chroma 16..240 |
| luma_in | input | 18 | Filtered luma, signed 15.3 |
| cr_in | input | 18 | Filtered red-difference chroma, signed 15.3 |
| cb_in | input | 18 | Filtered blue-difference chroma, signed 15.3 |
| yc_out | output | 16 | [15:8] luma byte, [7:0] chroma byte |
| word_strobe | output | 1 | High on the first clock of each output word |

## Verification
The assertions check the timing rules on every cycle:
- the strobe alternates, and a loaded word stays stable through its second clock;
- the bus blanks after the line reference is sampled low;
- the bytes stay inside the selected broadcast limits whenever the offset path is active.

The arithmetic itself is left to the bench's scenarios:
- which bit window is used, the rounding bit, saturation at each clip boundary and the 128 offset;
- the red-then-blue ordering of the chroma source after each line start.

These scenarios compare exact byte values that no range property can pin down.

// File: rtl/yc_fmt_pkg.sv
package yc_fmt_pkg;

    localparam int FRAC_W = 3;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] y;
        logic [BYTE_W-1:0] c;
    } yc_word_t;

    typedef struct packed {
        yc_word_t word;
        logic     strobe;
        logic     slot;     // 0: red-difference next, 1: blue-difference next
    } fmt_state_t;

endpackage

// File: rtl/yc_luma_round.sv
module yc_luma_round
    import yc_fmt_pkg::*;
#(
    parameter int IN_W  = 18,
    parameter int WIN_W = 10
) (
    input  logic [IN_W-1:0]   raw_in,
    output logic [BYTE_W-1:0] byte_out
);
    localparam int SUM_W = WIN_W + 1;

    logic [WIN_W-1:0] win;
    logic             rnd;
    logic [SUM_W-1:0] sum;

    assign win = raw_in[FRAC_W+WIN_W-1:FRAC_W];
    assign rnd = raw_in[FRAC_W-1];

    always_comb begin
        sum = {win[WIN_W-1], win} + {{(SUM_W-1){1'b0}}, rnd};
        if (sum[SUM_W-1]) begin
            byte_out = '0;
        end else if (|sum[SUM_W-2:BYTE_W]) begin
            byte_out = '1;
        end else begin
            byte_out = sum[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/yc_chroma_round.sv
module yc_chroma_round
    import yc_fmt_pkg::*;
#(
    parameter int IN_W  = 18,
    parameter int WIN_W = 10
) (
    input  logic [IN_W-1:0]   raw_in,
    input  logic              norm,
    output logic [BYTE_W-1:0] byte_out
);
    localparam int NAR_W = WIN_W - 1;
    localparam int SUM_W = NAR_W + 1;
    localparam int TOP_W = SUM_W - BYTE_W + 1;

    logic [NAR_W-1:0] win;
    logic             rnd;
    logic [SUM_W-1:0] sum;
    logic [TOP_W-1:0] top;

    always_comb begin
        if (norm) begin
            win = raw_in[FRAC_W+NAR_W-1:FRAC_W];
            rnd = raw_in[FRAC_W-1];
        end else begin
            win = raw_in[FRAC_W+WIN_W-1:FRAC_W+1];
            rnd = raw_in[FRAC_W];
        end
        sum = {win[NAR_W-1], win} + {{(SUM_W-1){1'b0}}, rnd};
        top = sum[SUM_W-1:BYTE_W-1];
        if (top == '0 || top == '1) begin
            byte_out = sum[BYTE_W-1:0];
        end else if (sum[SUM_W-1]) begin
            byte_out = {1'b1, {(BYTE_W-1){1'b0}}};
        end else begin
            byte_out = {1'b0, {(BYTE_W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/yc_range.sv
module yc_range
    import yc_fmt_pkg::*;
#(
    parameter bit IS_CHROMA = 1'b0
) (
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              bypass,
    input  logic              sel,
    output logic [BYTE_W-1:0] byte_out
);
    localparam logic [BYTE_W-1:0] WIDE_LO = 8'd1;
    localparam logic [BYTE_W-1:0] WIDE_HI = 8'd254;
    localparam logic [BYTE_W-1:0] STD_LO  = 8'd16;
    localparam logic [BYTE_W-1:0] STD_HI  = IS_CHROMA ? 8'd240 : 8'd235;

    logic [BYTE_W-1:0] shifted;
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] hi;

    generate
        if (IS_CHROMA) begin : g_offset
            // adding 128 to a signed byte flips its sign bit
            assign shifted = {~byte_in[BYTE_W-1], byte_in[BYTE_W-2:0]};
        end else begin : g_plain
            assign shifted = byte_in;
        end
    endgenerate

    always_comb begin
        lo = sel ? WIDE_LO : STD_LO;
        hi = sel ? WIDE_HI : STD_HI;
        if (bypass) begin
            byte_out = byte_in;
        end else if (shifted < lo) begin
            byte_out = lo;
        end else if (shifted > hi) begin
            byte_out = hi;
        end else begin
            byte_out = shifted;
        end
    end
endmodule

// File: rtl/yc_out_formatter.sv
module yc_out_formatter
    import yc_fmt_pkg::*;
#(
    parameter int IN_W  = 18,
    parameter int WIN_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_act_n,
    input  logic            cfg_norm,
    input  logic            cfg_bypass,
    input  logic            cfg_sel,
    input  logic [IN_W-1:0] luma_in,
    input  logic [IN_W-1:0] cr_in,
    input  logic [IN_W-1:0] cb_in,
    output logic [15:0]     yc_out,
    output logic            word_strobe
);
    fmt_state_t st_d, st_q;

    logic [IN_W-1:0]   chroma_raw;
    logic [BYTE_W-1:0] luma_clip;
    logic [BYTE_W-1:0] chroma_clip;
    logic [BYTE_W-1:0] luma_rng;
    logic [BYTE_W-1:0] chroma_rng;

    assign chroma_raw = st_q.slot ? cb_in : cr_in;

    yc_luma_round #(.IN_W(IN_W), .WIN_W(WIN_W)) u_luma_round (
        .raw_in   (luma_in),
        .byte_out (luma_clip)
    );

    yc_chroma_round #(.IN_W(IN_W), .WIN_W(WIN_W)) u_chroma_round (
        .raw_in   (chroma_raw),
        .norm     (cfg_norm),
        .byte_out (chroma_clip)
    );

    yc_range #(.IS_CHROMA(1'b0)) u_luma_range (
        .byte_in  (luma_clip),
        .bypass   (cfg_bypass),
        .sel      (cfg_sel),
        .byte_out (luma_rng)
    );

    yc_range #(.IS_CHROMA(1'b1)) u_chroma_range (
        .byte_in  (chroma_clip),
        .bypass   (cfg_bypass),
        .sel      (cfg_sel),
        .byte_out (chroma_rng)
    );

    always_comb begin
        st_d = st_q;
        if (!line_act_n) begin
            st_d = '0;
        end else if (!st_q.strobe) begin
            st_d.word.y = luma_rng;
            st_d.word.c = chroma_rng;
            st_d.strobe = 1'b1;
        end else begin
            st_d.strobe = 1'b0;
            st_d.slot   = ~st_q.slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign yc_out      = st_q.word;
    assign word_strobe = st_q.strobe;
endmodule

// File: rtl/yc_fmt_checker.sv
module yc_fmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        line_act_n,
    input logic        cfg_bypass,
    input logic        cfg_sel,
    input logic [15:0] yc_out,
    input logic        word_strobe
);
    assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_strobe && line_act_n) |=> (!word_strobe && $stable(yc_out)));

    assert_strobe_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_strobe && line_act_n) |=> word_strobe);

    assert_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !line_act_n |=> (yc_out == 16'h0000 && !word_strobe));

    assert_wide_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_act_n && !word_strobe && !cfg_bypass && cfg_sel) |=>
        (yc_out[15:8] >= 8'd1 && yc_out[15:8] <= 8'd254 &&
         yc_out[7:0] >= 8'd1 && yc_out[7:0] <= 8'd254));

    assert_std_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_act_n && !word_strobe && !cfg_bypass && !cfg_sel) |=>
        (yc_out[15:8] >= 8'd16 && yc_out[15:8] <= 8'd235 &&
         yc_out[7:0] >= 8'd16 && yc_out[7:0] <= 8'd240));
endmodule

bind yc_out_formatter yc_fmt_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_act_n  (line_act_n),
    .cfg_bypass  (cfg_bypass),
    .cfg_sel     (cfg_sel),
    .yc_out      (yc_out),
    .word_strobe (word_strobe)
);

// File: tb/sim_yc_out_formatter.sv
module sim_yc_out_formatter;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    typedef struct packed {
        logic               norm;
        logic               bypass;
        logic               sel;
        logic signed [17:0] y;
        logic signed [17:0] c;
        logic [7:0]         ey;
        logic [7:0]         ec;
    } vec_t;

    // raw inputs are value*8 + fraction (15.3)
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b1, 1'b0,  18'sd804,   -18'sd28,  8'h65, 8'hFD}, // R1 R2 R4 round up
        '{1'b1, 1'b1, 1'b0, -18'sd40,    18'sd1600, 8'h00, 8'h7F}, // R1 neg, R2 sat hi
        '{1'b1, 1'b1, 1'b0,  18'sd2400, -18'sd1600, 8'hFF, 8'h80}, // R1 sat, R2 sat lo
        '{1'b1, 1'b1, 1'b0,  18'sd2036,  18'sd1020, 8'hFF, 8'h7F}, // R1 R2 round into clip
        '{1'b1, 1'b1, 1'b0,  18'sd2044, -18'sd1020, 8'hFF, 8'h81}, // R1 R2
        '{1'b0, 1'b1, 1'b0,  18'sd800,   18'sd800,  8'h64, 8'h32}, // R3 window
        '{1'b0, 1'b1, 1'b0, -18'sd4,     18'sd808,  8'h00, 8'h33}, // R3 round on int bit 0
        '{1'b0, 1'b1, 1'b0,  18'sd0,    -18'sd8,    8'h00, 8'h00}, // R3
        '{1'b0, 1'b1, 1'b0,  18'sd0,     18'sd2400, 8'h00, 8'h7F}, // R3 sat hi
        '{1'b0, 1'b1, 1'b0,  18'sd0,    -18'sd2400, 8'h00, 8'h80}, // R3 sat lo
        '{1'b1, 1'b0, 1'b1,  18'sd0,    -18'sd1024, 8'h01, 8'h01}, // R5 R6 floor
        '{1'b1, 1'b0, 1'b1,  18'sd2040,  18'sd1016, 8'hFE, 8'hFE}, // R5 R6 ceiling
        '{1'b1, 1'b0, 1'b1,  18'sd800,   18'sd0,    8'h64, 8'h80}, // R5 offset
        '{1'b1, 1'b0, 1'b0,  18'sd80,   -18'sd960,  8'h10, 8'h10}, // R7 floor
        '{1'b1, 1'b0, 1'b0,  18'sd1920,  18'sd920,  8'hEB, 8'hF0}, // R7 ceiling
        '{1'b1, 1'b0, 1'b0,  18'sd800,   18'sd160,  8'h64, 8'h94}, // R7 pass
        '{1'b1, 1'b1, 1'b0,  18'sd4800,  18'sd0,    8'h00, 8'h00}  // R1 window wraps
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_act_n = 1'b0;
    logic        cfg_norm = 1'b1;
    logic        cfg_bypass = 1'b1;
    logic        cfg_sel = 1'b0;
    logic [17:0] luma_in = '0;
    logic [17:0] cr_in = '0;
    logic [17:0] cb_in = '0;
    logic [15:0] yc_out;
    logic        word_strobe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    yc_out_formatter u0 (
        .clk(clk), .rst_n(rst_n), .line_act_n(line_act_n),
        .cfg_norm(cfg_norm), .cfg_bypass(cfg_bypass), .cfg_sel(cfg_sel),
        .luma_in(luma_in), .cr_in(cr_in), .cb_in(cb_in),
        .yc_out(yc_out), .word_strobe(word_strobe)
    );

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // from a negedge with line high, bring the sequence back to its start
    task automatic restart_line();
        line_act_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        line_act_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        if (!done) $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        line_act_n = 1'b1;
        @(negedge clk);
        check("R11 reset", {word_strobe, yc_out}, 17'h0);
        rst_n = 1'b1;
        @(negedge clk);
        restart_line();

        // table walk: cr and cb equal so both word slots expect the same byte
        for (int i = 0; i < NVEC; i++) begin
            cfg_norm = VECS[i].norm;
            cfg_bypass = VECS[i].bypass;
            cfg_sel = VECS[i].sel;
            luma_in = VECS[i].y;
            cr_in = VECS[i].c;
            cb_in = VECS[i].c;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R1-R7 vector %0d first clock", i),
                  {word_strobe, yc_out}, {1'b1, VECS[i].ey, VECS[i].ec});
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R8 vector %0d second clock", i),
                  {word_strobe, yc_out}, {1'b0, VECS[i].ey, VECS[i].ec});
        end

        // R9: interleave order, distinct chroma sources (norm=1, bypass=1: raw 8 -> 01, 16 -> 02)
        cfg_norm = 1'b1; cfg_bypass = 1'b1; cfg_sel = 1'b0;
        luma_in = 18'd80; cr_in = 18'd8; cb_in = 18'd16;
        restart_line();
        @(posedge clk); @(negedge clk);
        check("R9 first word carries cr", {word_strobe, yc_out}, {1'b1, 8'h0A, 8'h01});
        // R8: inputs changed during hold clock have no effect
        luma_in = 18'd400; cr_in = 18'd40; cb_in = 18'd48;
        @(posedge clk); @(negedge clk);
        check("R8 hold ignores inputs", {word_strobe, yc_out}, {1'b0, 8'h0A, 8'h01});
        @(posedge clk); @(negedge clk);
        check("R9 second word carries cb", {word_strobe, yc_out}, {1'b1, 8'h32, 8'h06});
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check("R9 third word carries cr", {word_strobe, yc_out}, {1'b1, 8'h32, 8'h05});

        // R10: blanking mid-word, then R9 restart with cr
        line_act_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R10 blank", {word_strobe, yc_out}, 17'h0);
        @(posedge clk); @(negedge clk);
        check("R10 blank held", {word_strobe, yc_out}, 17'h0);
        line_act_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9 restart carries cr", {word_strobe, yc_out}, {1'b1, 8'h32, 8'h05});

        // R11: reset mid-line clears outputs
        rst_n = 1'b0;
        #1;
        check("R11 async reset", {word_strobe, yc_out}, 17'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule